// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus whose data line is held low by a target that stopped partway through a byte. A single-cycle start request first runs a bus-free check: the block watches SDA for a bounded window and finishes at once, with no clocking, if the line goes high. If SDA is still low when the window closes, the block drives SCL through a fixed train of nine low/high pulses with SDA released. This gives the stuck target enough clocks to shift out its byte and let go of the line. The block then builds a stop condition in four timed phases and samples SDA to report success or failure.

The block only drives the output enables of the two open-drain pads (1 = pull the line low) and reads the SDA pad back. All phase timing comes from a microsecond prescaler set by a clock-cycles-per-microsecond parameter. Deciding when recovery is needed, running ordinary transfers, and coping with clock stretching during recovery are left to the surrounding controller. The SDA input is assumed to be already synchronised to the clock.

Top module: `i2c_unstick_seq`

## Requirements
- R1: After the bus-free window expires, SCL is clocked exactly FLUSH_PULSES (default 9) times. Each pulse is SCL driven low (scl_oe=1) for one phase and then released (scl_oe=0) for one phase. One phase is PHASE_US*CLKS_PER_US clock cycles.
- R2: SDA is released (sda_oe=0) for the whole pulse train.
- R3: After the last released-SCL phase comes one gap phase with SCL driven low and SDA released.
- R4: The stop is built in three further phases, each one phase long, in this order: SDA driven low with SCL still driven low; SCL released with SDA held low; SDA released with SCL released. SDA is therefore only released while SCL is released.
- R5: At the end of the final stop phase, SDA is sampled and done rises. fail=1 if SDA reads low and fail=0 if it reads high. fail is never 1 without done.
- R6: Bus-free check. After start, if SDA is seen high within FREE_WAIT_US*CLKS_PER_US cycles, done rises the cycle after SDA is seen high, with fail=0 and no SCL activity. Otherwise scl_oe first rises FREE_WAIT_US*CLKS_PER_US cycles after the start edge.
- R7: start is a one-cycle pulse that is accepted only while the block is idle. A start during a sequence has no effect on the pulse count or on the length of that sequence.
- R8: busy is 1 from the cycle after an accepted start until done rises. done and fail hold their values until the next accepted start, which clears both.
- R9: In reset and whenever busy is 0, both line enables are 0, so both lines are released. Reset clears busy, done and fail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a recovery attempt |
| sda_in | input | 1 | Synchronised SDA pad level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Attempt finished; held until next start |
| fail | output | 1 | SDA still low after recovery; held until next start |

## Verification
The assertions check every cycle that SDA only changes while SCL is in the correct state for a stop, that SDA stays released during the pulse train, and that both enables are clear whenever the block is idle. They also check that fail never appears without done, and that the pulse and microsecond counters stay inside their ranges. The exact phase lengths, the pulse count, the gap and stop ordering, the bus-free window length, the pass and fail outcome against a target model that lets go after a few clocks or never lets go, and the fact that a start during a sequence is ignored can only be shown by the bench's scenarios. Those scenarios measure every run of the two enables against the phase length.

// File: rtl/i2c_unstick_pkg.sv
// Shared types for the I2C bus recovery sequencer.
package i2c_unstick_pkg;

    // Sequencer states; the flush and stop phases are visited in declaration order.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FREE_CHK = 3'd1,
        ST_FLUSH_LO = 3'd2,
        ST_FLUSH_HI = 3'd3,
        ST_GAP      = 3'd4,
        ST_STOP_SET = 3'd5,
        ST_STOP_CLK = 3'd6,
        ST_STOP_REL = 3'd7
    } unstick_state_t;

endpackage

// File: rtl/i2c_span_timer.sv
// Microsecond-based span timer.
// A clock prescaler makes a one-microsecond step and a second counter counts
// steps. 'expired' is high for one cycle on the last cycle of a span of
// SPAN_US*CLKS_PER_US cycles, counted from the edge at which clr was high.
// The timer then wraps and starts a new span.
// Assumes CLKS_PER_US >= 1 and SPAN_US >= 1.
module i2c_span_timer #(
    parameter int CLKS_PER_US = 125,
    parameter int SPAN_US     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int CLK_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam int US_W  = (SPAN_US > 1) ? $clog2(SPAN_US) : 1;
    localparam logic [CLK_W-1:0] CLK_LAST = CLK_W'(CLKS_PER_US - 1);
    localparam logic [US_W-1:0]  US_LAST  = US_W'(SPAN_US - 1);

    logic [CLK_W-1:0] clk_cnt;
    logic [US_W-1:0]  us_cnt;
    logic             us_step;

    assign us_step = (clk_cnt == CLK_LAST);
    assign expired = us_step && (us_cnt == US_LAST);

    // Advance the prescaler and the microsecond count; restart on clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            clk_cnt <= '0;
            us_cnt  <= '0;
        end else if (us_step) begin
            clk_cnt <= '0;
            us_cnt  <= expired ? '0 : us_cnt + 1'b1;
        end else begin
            clk_cnt <= clk_cnt + 1'b1;
        end
    end

    // R1: the microsecond count never runs past the span
    p_us_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        us_cnt <= US_LAST);

endmodule

// File: rtl/i2c_flush_counter.sv
// Counts the completed SCL pulses of the flush train.
// 'last' is high while the count equals PULSES-1, so it is high during the
// final released-SCL phase. Assumes PULSES >= 1.
module i2c_flush_counter #(
    parameter int PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = (PULSES > 1) ? $clog2(PULSES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSES - 1);

    logic [CNT_W-1:0] cnt;

    assign last = (cnt == CNT_LAST);

    // Hold the pulse count; cleared between sequences.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: the pulse count stays within the configured train length
    p_pulse_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST);

endmodule

// File: rtl/i2c_unstick_fsm.sv
// Phase sequencer for bus recovery.
// Walks through: bus-free check, flush pulses, gap, three stop phases.
// It registers the line enables and busy from the next state, so they change
// in the same cycle as the state. It assumes the timers are restarted through
// the clear outputs it drives, and that sda_in is synchronous to clk.
module i2c_unstick_fsm
    import i2c_unstick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sda_in,
    input  logic phase_exp,
    input  logic free_exp,
    input  logic flush_last,
    output logic phase_clr,
    output logic free_clr,
    output logic flush_clr,
    output logic flush_inc,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic done,
    output logic fail
);
    unstick_state_t st, nxt;

    // Choose the next phase from the current one and the timer events.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:     if (start) nxt = ST_FREE_CHK;
            ST_FREE_CHK: begin
                if (sda_in)        nxt = ST_IDLE;
                else if (free_exp) nxt = ST_FLUSH_LO;
            end
            ST_FLUSH_LO: if (phase_exp) nxt = ST_FLUSH_HI;
            ST_FLUSH_HI: if (phase_exp) nxt = flush_last ? ST_GAP : ST_FLUSH_LO;
            ST_GAP:      if (phase_exp) nxt = ST_STOP_SET;
            ST_STOP_SET: if (phase_exp) nxt = ST_STOP_CLK;
            ST_STOP_CLK: if (phase_exp) nxt = ST_STOP_REL;
            ST_STOP_REL: if (phase_exp) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Timer and counter control derived from the phase change.
    assign phase_clr = (nxt != st);
    assign free_clr  = (st != ST_FREE_CHK);
    assign flush_clr = (st == ST_IDLE);
    assign flush_inc = (st == ST_FLUSH_HI) && phase_exp;

    // Register the state together with the pad enables and busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            busy   <= 1'b0;
        end else begin
            st     <= nxt;
            scl_oe <= (nxt == ST_FLUSH_LO) || (nxt == ST_GAP) || (nxt == ST_STOP_SET);
            sda_oe <= (nxt == ST_STOP_SET) || (nxt == ST_STOP_CLK);
            busy   <= (nxt != ST_IDLE);
        end
    end

    // Latch the outcome; hold it until the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else if (st == ST_IDLE && start) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else if (st == ST_FREE_CHK && sda_in) begin
            done <= 1'b1;
            fail <= 1'b0;
        end else if (st == ST_STOP_REL && phase_exp) begin
            done <= 1'b1;
            fail <= !sda_in;
        end
    end

    // R2: SDA stays released throughout the pulse train
    p_flush_sda_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FLUSH_LO || st == ST_FLUSH_HI) |-> !sda_oe);

    // R5: a failure is only reported together with completion
    p_fail_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R8: completion is never flagged while a sequence is running
    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/i2c_unstick_seq.sv
// I2C bus recovery sequencer, top level.
// It joins the phase sequencer, a per-phase timer, the bus-free window timer
// and the flush pulse counter. The outputs are open-drain enables: 1 pulls the
// line low. It assumes sda_in is synchronised and that no other master drives
// the bus during recovery.
module i2c_unstick_seq #(
    parameter int CLKS_PER_US  = 125,
    parameter int PHASE_US     = 5,
    parameter int FLUSH_PULSES = 9,
    parameter int FREE_WAIT_US = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic done,
    output logic fail
);
    logic phase_clr, phase_exp;
    logic free_clr, free_exp;
    logic flush_clr, flush_inc, flush_last;

    i2c_unstick_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .sda_in     (sda_in),
        .phase_exp  (phase_exp),
        .free_exp   (free_exp),
        .flush_last (flush_last),
        .phase_clr  (phase_clr),
        .free_clr   (free_clr),
        .flush_clr  (flush_clr),
        .flush_inc  (flush_inc),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .busy       (busy),
        .done       (done),
        .fail       (fail)
    );

    i2c_span_timer #(.CLKS_PER_US(CLKS_PER_US), .SPAN_US(PHASE_US)) u_phase_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (phase_clr),
        .expired (phase_exp)
    );

    i2c_span_timer #(.CLKS_PER_US(CLKS_PER_US), .SPAN_US(FREE_WAIT_US)) u_free_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (free_clr),
        .expired (free_exp)
    );

    i2c_flush_counter #(.PULSES(FLUSH_PULSES)) u_flush_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_clr),
        .inc   (flush_inc),
        .last  (flush_last)
    );

    // R4: SDA is pulled low only while SCL is already held low
    p_stop_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> scl_oe);

    // R4: SDA is let go only while SCL is released, forming the stop
    p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_oe);

    // R9: an idle block leaves both lines released
    p_idle_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/i2c_unstick_seq_bench.sv
// Directed bench for the recovery sequencer, with a target model on SDA.
module i2c_unstick_seq_bench;
    localparam int CPU  = 2;
    localparam int PHU  = 5;
    localparam int NPUL = 9;
    localparam int FWU  = 50;
    localparam int P    = PHU * CPU;   // cycles per phase
    localparam int W    = FWU * CPU;   // bus-free window in cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic tgt_hold = 1'b0;
    logic sda_in;
    logic scl_oe, sda_oe, busy, done, fail;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // Measurements of one observed sequence
    int n, first_scl, hi_cnt, lo_cnt, hi_cur, lo_cur, rises;
    int hi_len[16];
    int lo_len[16];
    int sda_rises, sda_cur, sda_len, sda_start_scl, scl_lo_at_rel, tail;
    int done_n, busy_at1;
    bit sda_in_flush, rel_seen, fail_at_done, finished;

    always #4 clk = ~clk;

    // Open-drain SDA: low if the block or the target pulls it
    assign sda_in = !sda_oe && !tgt_hold;

    i2c_unstick_seq #(
        .CLKS_PER_US(CPU), .PHASE_US(PHU), .FLUSH_PULSES(NPUL), .FREE_WAIT_US(FWU)
    ) u_i2c_unstick_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .fail(fail)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue a start and follow the sequence to completion, recording every run.
    // hold_mode: 0 none, 1 forever, 2 until rel_k SCL pulses, 3 until cycle rel_k
    task automatic observe(input int hold_mode, input int rel_k, input int poke_at);
        bit p_scl, p_sda;
        n = 0; first_scl = 0; hi_cnt = 0; lo_cnt = 0; hi_cur = 0; lo_cur = 0;
        rises = 0; sda_rises = 0; sda_cur = 0; sda_len = 0; sda_start_scl = 0;
        scl_lo_at_rel = -1; tail = 0; done_n = 0; busy_at1 = 0;
        sda_in_flush = 0; rel_seen = 0; fail_at_done = 0; finished = 0;
        for (int i = 0; i < 16; i++) begin hi_len[i] = 0; lo_len[i] = 0; end
        p_scl = 0; p_sda = 0;
        @(negedge clk);
        tgt_hold = (hold_mode != 0);
        start = 1'b1;
        for (int k = 0; k < 4000; k++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (n == 1) begin start = 1'b0; busy_at1 = busy; end
            if (poke_at > 0 && n == poke_at) start = 1'b1;
            if (poke_at > 0 && n == poke_at + 1) start = 1'b0;
            if (scl_oe && !p_scl) rises++;
            if (hold_mode == 2 && rises >= rel_k) tgt_hold = 1'b0;
            if (hold_mode == 3 && n >= rel_k) tgt_hold = 1'b0;
            if (scl_oe) begin
                if (!p_scl) begin
                    if (first_scl == 0) first_scl = n;
                    if (hi_cnt > 0 && lo_cnt < 16) begin lo_len[lo_cnt] = lo_cur; lo_cnt++; end
                    hi_cur = 0;
                end
                hi_cur++;
            end else begin
                if (p_scl) begin
                    if (hi_cnt < 16) hi_len[hi_cnt] = hi_cur;
                    hi_cnt++;
                    lo_cur = 0;
                end
                lo_cur++;
            end
            if (sda_oe && hi_cnt < NPUL) sda_in_flush = 1;
            if (sda_oe && !p_sda) begin sda_rises++; sda_start_scl = hi_cur; end
            if (sda_oe) sda_cur++;
            if (!sda_oe && p_sda) begin
                sda_len = sda_cur;
                scl_lo_at_rel = scl_oe ? 0 : lo_cur;
                rel_seen = 1;
            end
            if (rel_seen && busy) tail++;
            p_scl = scl_oe;
            p_sda = sda_oe;
            if (done) begin
                done_n = n; fail_at_done = fail; finished = 1;
                break;
            end
        end
        chk(finished, "R5", "sequence completed", finished, 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!scl_oe && !sda_oe, "R9", "lines released in reset", {scl_oe, sda_oe}, 0);
        chk(!busy && !done && !fail, "R9", "status clear in reset", {busy, done, fail}, 0);
    endtask

    task automatic t_bus_free;
        observe(0, 0, 0);
        chk(done_n == 2, "R6", "free bus done cycle", done_n, 2);
        chk(first_scl == 0, "R6", "no SCL on free bus", first_scl, 0);
        chk(fail_at_done == 0, "R6", "free bus fail flag", fail_at_done, 0);
        chk(busy_at1 == 1, "R8", "busy after start", busy_at1, 1);
    endtask

    task automatic t_late_release;
        observe(3, 20, 0);
        chk(done_n == 21, "R6", "late release done cycle", done_n, 21);
        chk(hi_cnt == 0 && first_scl == 0, "R6", "no SCL after late release", hi_cnt, 0);
        chk(fail_at_done == 0, "R6", "late release fail flag", fail_at_done, 0);
    endtask

    task automatic check_waveform(input string tag);
        bit ok_hi, ok_lo;
        ok_hi = 1; ok_lo = 1;
        chk(first_scl == W + 1, "R6", "window before first SCL pulse", first_scl, W + 1);
        chk(hi_cnt == NPUL + 1, "R1", "SCL low-drive runs", hi_cnt, NPUL + 1);
        for (int i = 0; i < NPUL; i++) if (hi_len[i] != P) ok_hi = 0;
        for (int i = 0; i < NPUL; i++) if (lo_len[i] != P) ok_lo = 0;
        chk(ok_hi, "R1", "SCL low phase lengths", hi_len[0], P);
        chk(ok_lo, "R1", "SCL released phase lengths", lo_len[0], P);
        chk(!sda_in_flush, "R2", "SDA driven during flush", sda_in_flush, 0);
        chk(hi_len[NPUL] == 2 * P, "R3", "gap plus stop setup length", hi_len[NPUL], 2 * P);
        chk(sda_start_scl == P + 1, "R3", "gap before SDA pulled", sda_start_scl, P + 1);
        chk(sda_rises == 1 && sda_len == 2 * P, "R4", "SDA low span", sda_len, 2 * P);
        chk(scl_lo_at_rel == P + 1, "R4", "SCL released before SDA", scl_lo_at_rel, P + 1);
        chk(tail == P, "R4", "final stop phase length", tail, P);
        chk(done_n == W + 1 + (2 * NPUL + 4) * P, tag, "total sequence length",
            done_n, W + 1 + (2 * NPUL + 4) * P);
    endtask

    task automatic t_recover_ok;
        observe(2, 3, 0);
        check_waveform("R1");
        chk(fail_at_done == 0, "R5", "fail after release", fail_at_done, 0);
    endtask

    task automatic t_recover_stuck;
        observe(1, 0, 0);
        check_waveform("R1");
        chk(fail_at_done == 1, "R5", "fail when stuck", fail_at_done, 1);
    endtask

    task automatic t_start_while_busy;
        observe(1, 0, W + 30);
        check_waveform("R7");
        chk(hi_cnt == NPUL + 1, "R7", "pulse count with extra start", hi_cnt, NPUL + 1);
    endtask

    task automatic t_hold_and_clear;
        for (int i = 0; i < 20; i++) @(negedge clk);
        chk(done && fail, "R8", "done/fail held", {done, fail}, 3);
        chk(!scl_oe && !sda_oe, "R9", "lines released after finish", {scl_oe, sda_oe}, 0);
        observe(0, 0, 0);
        chk(done && !fail, "R8", "new start clears fail", {done, fail}, 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_bus_free();
        t_late_release();
        t_recover_ok();
        t_recover_stuck();
        t_hold_and_clear();
        t_start_while_busy();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule